// File: doc/BRIEF.md
# SD Host Wrapper Register Front End

This block is the shared register file that sits in front of one or two standard SD host slot controllers. Software reaches it through a 32-bit word-addressed bus inside a 4 KiB window. It holds the wrapper's own settings: a slot information word with a reset-request bit that clears itself, a card-detect debounce setting, and three plain storage words for bus control, write-protect polarity and card-detect control. For each slot it also keeps a 64-bit capability word, reachable as two 32-bit halves, and a 32-bit maximum-current word. Software can rewrite both before the slot controllers report them.

The block also gathers the interrupt line of each slot. It keeps a status word with one bit per slot that follows the live line level, and it drives one combined interrupt output. From the request address it decodes which slot's own register bank is being addressed and exports one select per slot, so that the slot controllers' register banks can hang off the same bus.

A two-state machine runs the bus. In ST_IDLE the block is ready. An accepted request (transition IDLE->RESP) performs the write, or captures the read data. In ST_RESP the response is valid for one cycle, and the machine then always returns to ST_IDLE (transition RESP->IDLE). The slot-count parameter NUM_SLOTS (1 or 2) sets the slot-present bits at reset and switches slot 1 off.

Top module: `sdhost_wrap_regs`

## Requirements
- R1: After reset, offset 0x000 reads 0x00010000 with NUM_SLOTS=1 and 0x00030000 with NUM_SLOTS=2 (bit 16 is slot 0 present, bit 17 is slot 1 present). Offset 0x004 reads 0x00000005. Offsets 0x008, 0x0EC and 0x0F0 read 0. Each slot's capability word reads CAP_RESET and its maximum-current word reads MAXCUR_RESET.
- R2: A write to offset 0x000 stores the write data with bit 0 forced to 0, so bit 0 never reads back as 1.
- R3: Offsets 0x008, 0x0EC and 0x0F0 are plain 32-bit read/write storage.
- R4: For slot 0, offset 0x010 holds the low 32 bits of the capability word and offset 0x014 holds the high 32 bits. For slot 1 these are offsets 0x020 and 0x024. A write to one half leaves the other half unchanged.
- R5: Offset 0x018 holds slot 0's maximum-current word and offset 0x028 holds slot 1's. Each is read/write.
- R6: Bit n of offset 0x0FC is the level of slot_irq_in[n] sampled at the previous rising clock edge. Writes to 0x0FC have no effect.
- R7: irq_out is high exactly when at least one bit of the status word at 0x0FC is set.
- R8: With NUM_SLOTS=1, offsets 0x020, 0x024 and 0x028 read 0 and writes to them are dropped. slot_irq_in[1] has no effect on the status word or on irq_out, and slot_sel[1] stays 0.
- R9: A read of any other offset, and of any address with bits 1:0 not zero, returns 0. A write there changes nothing.
- R10: req_ready is high in ST_IDLE and low in ST_RESP. rsp_valid is high exactly in the cycle after a request is accepted, and rsp_rdata then carries the read data (0 for a write).
- R11: slot_sel[n] is high, decoded combinationally from req_addr alone, when req_addr[11:8] equals n+1 and n < NUM_SLOTS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request (ST_IDLE) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address inside the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response cycle (ST_RESP) |
| rsp_rdata | output | 32 | Read data, valid with rsp_valid |
| slot_irq_in | input | 2 | Interrupt level from each slot controller |
| irq_out | output | 1 | Combined interrupt |
| slot_sel | output | 2 | Slot register bank selected by req_addr |

## Verification
A read of the interrupt status word and a change of a slot interrupt level can land on the same clock edge. The bench provokes this by raising slot_irq_in[1] at the same falling edge at which it presents a read of 0x0FC. The response must carry the old status (0), because the data is captured at the edge that also updates the status. In that same response cycle irq_out must already be high. A second instance with NUM_SLOTS=1 sees the same stimulus and must keep irq_out low.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 12;
    localparam int MAX_SLOTS = 2;
    localparam int SLOT_LSB  = 8;   // slot banks sit at (n+1)*0x100

    localparam logic [ADDR_W-1:0] OFS_INFO     = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_DEBOUNCE = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_BUSCTL   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_WPPOL    = 12'h0EC;
    localparam logic [ADDR_W-1:0] OFS_CDET     = 12'h0F0;
    localparam logic [ADDR_W-1:0] OFS_IRQSTAT  = 12'h0FC;
    localparam logic [ADDR_W-1:0] OFS_SHADOW0  = 12'h010;
    localparam logic [ADDR_W-1:0] SHADOW_STEP  = 12'h010;

    localparam int                PRESENT_LSB   = 16;
    localparam logic [DATA_W-1:0] DEBOUNCE_INIT = 32'h0000_0005;

    typedef enum logic {ST_IDLE, ST_RESP} bus_state_t;

    function automatic logic [ADDR_W-1:0] shadow_base(input int slot);
        return OFS_SHADOW0 + SHADOW_STEP * ADDR_W'(slot);
    endfunction
endpackage

// File: rtl/sdw_bus_fsm.sv
module sdw_bus_fsm
    import sdw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    output logic req_ready,
    output logic accept,
    output logic rsp_valid
);
    bus_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nxt = ST_RESP;
            ST_RESP: state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        rsp_valid = (state == ST_RESP);
        accept    = req_valid && (state == ST_IDLE);
    end
endmodule

// File: rtl/sdw_slot_bank.sv
module sdw_slot_bank
    import sdw_pkg::*;
#(
    parameter logic [63:0]       CAP_RESET    = 64'h0,
    parameter logic [DATA_W-1:0] MAXCUR_RESET = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cap_lo,
    input  logic              wr_cap_hi,
    input  logic              wr_maxcur,
    input  logic [DATA_W-1:0] wdata,
    output logic [63:0]       cap_word,
    output logic [DATA_W-1:0] maxcur
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_word <= CAP_RESET;
            maxcur   <= MAXCUR_RESET;
        end else begin
            if (wr_cap_lo) cap_word[31:0]  <= wdata;
            if (wr_cap_hi) cap_word[63:32] <= wdata;
            if (wr_maxcur) maxcur          <= wdata;
        end
    end
endmodule

// File: rtl/sdw_irq_collect.sv
module sdw_irq_collect
    import sdw_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MAX_SLOTS-1:0] slot_irq_in,
    output logic [MAX_SLOTS-1:0] status,
    output logic                 irq_out
);
    for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_bit
        if (g < NUM_SLOTS) begin : g_live
            always_ff @(posedge clk) begin
                if (!rst_n) status[g] <= 1'b0;
                else        status[g] <= slot_irq_in[g];
            end
        end else begin : g_off
            assign status[g] = 1'b0;
        end
    end

    assign irq_out = |status;
endmodule

// File: rtl/sdhost_wrap_regs.sv
module sdhost_wrap_regs
    import sdw_pkg::*;
#(
    parameter int                NUM_SLOTS    = 2,
    parameter logic [63:0]       CAP_RESET    = 64'h0000_0007_21E8_0080,
    parameter logic [DATA_W-1:0] MAXCUR_RESET = 32'h0000_0040
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_valid,
    output logic [DATA_W-1:0]    rsp_rdata,
    input  logic [MAX_SLOTS-1:0] slot_irq_in,
    output logic                 irq_out,
    output logic [MAX_SLOTS-1:0] slot_sel
);
    localparam logic [DATA_W-1:0] INFO_INIT =
        DATA_W'(((1 << NUM_SLOTS) - 1) << PRESENT_LSB);

    logic accept, wr_go;
    logic [DATA_W-1:0] info_q, debounce_q, busctl_q, wppol_q, cdet_q;
    logic [DATA_W-1:0] rd_val;
    logic [MAX_SLOTS-1:0] irq_status;
    logic [63:0]       cap_word [MAX_SLOTS];
    logic [DATA_W-1:0] maxcur   [MAX_SLOTS];

    sdw_bus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .accept    (accept),
        .rsp_valid (rsp_valid)
    );

    assign wr_go = accept && req_write;

    for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_slot
        localparam logic [ADDR_W-1:0] BASE = shadow_base(g);
        localparam bit                LIVE = (g < NUM_SLOTS);
        sdw_slot_bank #(
            .CAP_RESET    (CAP_RESET),
            .MAXCUR_RESET (MAXCUR_RESET)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_cap_lo (LIVE && wr_go && req_addr == BASE),
            .wr_cap_hi (LIVE && wr_go && req_addr == BASE + 12'h004),
            .wr_maxcur (LIVE && wr_go && req_addr == BASE + 12'h008),
            .wdata     (req_wdata),
            .cap_word  (cap_word[g]),
            .maxcur    (maxcur[g])
        );
        assign slot_sel[g] = LIVE &&
            (req_addr[ADDR_W-1:SLOT_LSB] == (ADDR_W-SLOT_LSB)'(g + 1));
    end

    sdw_irq_collect #(.NUM_SLOTS(NUM_SLOTS)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_irq_in (slot_irq_in),
        .status      (irq_status),
        .irq_out     (irq_out)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            info_q     <= INFO_INIT;
            debounce_q <= DEBOUNCE_INIT;
            busctl_q   <= '0;
            wppol_q    <= '0;
            cdet_q     <= '0;
        end else if (wr_go) begin
            unique case (req_addr)
                OFS_INFO:     info_q     <= {req_wdata[DATA_W-1:1], 1'b0};
                OFS_DEBOUNCE: debounce_q <= req_wdata;
                OFS_BUSCTL:   busctl_q   <= req_wdata;
                OFS_WPPOL:    wppol_q    <= req_wdata;
                OFS_CDET:     cdet_q     <= req_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_val = '0;
        unique case (req_addr)
            OFS_INFO:     rd_val = info_q;
            OFS_DEBOUNCE: rd_val = debounce_q;
            OFS_BUSCTL:   rd_val = busctl_q;
            OFS_WPPOL:    rd_val = wppol_q;
            OFS_CDET:     rd_val = cdet_q;
            OFS_IRQSTAT:  rd_val = DATA_W'(irq_status);
            default: begin
                for (int s = 0; s < NUM_SLOTS; s++) begin
                    if (req_addr == shadow_base(s))           rd_val = cap_word[s][31:0];
                    if (req_addr == shadow_base(s) + 12'h004) rd_val = cap_word[s][63:32];
                    if (req_addr == shadow_base(s) + 12'h008) rd_val = maxcur[s];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (accept) rsp_rdata <= req_write ? '0 : rd_val;
    end
endmodule

// File: rtl/sdw_chk.sv
module sdw_chk
    import sdw_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 rsp_valid,
    input logic [DATA_W-1:0]    rsp_rdata,
    input logic [MAX_SLOTS-1:0] slot_irq_in,
    input logic                 irq_out,
    input logic [MAX_SLOTS-1:0] slot_sel
);
    localparam logic [MAX_SLOTS-1:0] LIVE_MASK = MAX_SLOTS'((1 << NUM_SLOTS) - 1);

    assert_rsp_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    assert_busy_in_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_single_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_info_bit0_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write && req_addr == OFS_INFO) |=> !rsp_rdata[0]);

    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_irq_in & LIVE_MASK) != '0) |=> irq_out);

    assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_irq_in & LIVE_MASK) == '0) |=> !irq_out);

    assert_sel_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_sel));

    assert_sel_slot1_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (NUM_SLOTS < 2) |-> !slot_sel[1]);
endmodule

bind sdhost_wrap_regs sdw_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .slot_irq_in (slot_irq_in),
    .irq_out     (irq_out),
    .slot_sel    (slot_sel)
);

// File: tb/sdhost_wrap_regs_tb.sv
module sdhost_wrap_regs_tb;
    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] CAP_R      = 64'h0000_0007_21E8_0080;
    localparam logic [31:0] MC_R       = 32'h0000_0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  slot_irq_in = '0;
    logic        rdy0, rdy1, rv0, rv1, irq0, irq1;
    logic [31:0] rd0, rd1;
    logic [1:0]  sel0, sel1;

    int n_chk = 0, n_fail = 0, hs_bad = 0;

    logic [31:0] m_info, m_deb, m_bus, m_wp, m_cd, m_mc0, m_mc1;
    logic [63:0] m_cap0, m_cap1;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdhost_wrap_regs #(.NUM_SLOTS(2), .CAP_RESET(CAP_R), .MAXCUR_RESET(MC_R)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy0),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rv0), .rsp_rdata(rd0), .slot_irq_in(slot_irq_in),
        .irq_out(irq0), .slot_sel(sel0));

    sdhost_wrap_regs #(.NUM_SLOTS(1), .CAP_RESET(CAP_R), .MAXCUR_RESET(MC_R)) u_dut1 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy1),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rv1), .rsp_rdata(rd1), .slot_irq_in(slot_irq_in),
        .irq_out(irq1), .slot_sel(sel1));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        case (a)
            12'h000: return m_info;
            12'h004: return m_deb;
            12'h008: return m_bus;
            12'h0EC: return m_wp;
            12'h0F0: return m_cd;
            12'h010: return m_cap0[31:0];
            12'h014: return m_cap0[63:32];
            12'h018: return m_mc0;
            12'h020: return m_cap1[31:0];
            12'h024: return m_cap1[63:32];
            12'h028: return m_mc1;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_wr(input logic [11:0] a, input logic [31:0] d);
        case (a)
            12'h000: m_info = {d[31:1], 1'b0};
            12'h004: m_deb  = d;
            12'h008: m_bus  = d;
            12'h0EC: m_wp   = d;
            12'h0F0: m_cd   = d;
            12'h010: m_cap0[31:0]  = d;
            12'h014: m_cap0[63:32] = d;
            12'h018: m_mc0 = d;
            12'h020: m_cap1[31:0]  = d;
            12'h024: m_cap1[63:32] = d;
            12'h028: m_mc1 = d;
            default: ;
        endcase
    endtask

    task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] r0, output logic [31:0] r1);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (!rv0 || !rv1 || rdy0 || rdy1) hs_bad++;
        r0 = rd0; r1 = rd1;
        if (wr) model_wr(a, d);
        @(negedge clk);
        if (rv0 || !rdy0) hs_bad++;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] x0, x1;
        xfer(1'b1, a, d, x0, x1);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] r0, output logic [31:0] r1);
        xfer(1'b0, a, 32'h0, r0, r1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] a0, a1;
        logic [11:0] offs [13];
        offs = '{12'h000, 12'h004, 12'h008, 12'h010, 12'h014, 12'h018, 12'h020,
                 12'h024, 12'h028, 12'h0EC, 12'h0F0, 12'h00C, 12'h030};
        a0 = $urandom(32'd2024);
        m_info = 32'h0003_0000; m_deb = 32'h5; m_bus = 0; m_wp = 0; m_cd = 0;
        m_cap0 = CAP_R; m_cap1 = CAP_R; m_mc0 = MC_R; m_mc1 = MC_R;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state of the handshake
        check("R10 ready after reset", {30'b0, rdy0, rv0}, 32'h2);

        // R1 reset values
        rd(12'h000, a0, a1);
        check("R1 info 2 slots", a0, 32'h0003_0000);
        check("R1 info 1 slot", a1, 32'h0001_0000);
        rd(12'h004, a0, a1); check("R1 debounce", a0, 32'h5);
        rd(12'h008, a0, a1); check("R1 bus", a0, 32'h0);
        rd(12'h0EC, a0, a1); check("R1 wp", a0, 32'h0);
        rd(12'h0F0, a0, a1); check("R1 cdet", a0, 32'h0);
        rd(12'h010, a0, a1); check("R1 cap0 lo", a0, CAP_R[31:0]);
        rd(12'h024, a0, a1); check("R1 cap1 hi", a0, CAP_R[63:32]);
        check("R8 cap1 hi one slot", a1, 32'h0);
        rd(12'h018, a0, a1); check("R1 maxcur0", a0, MC_R);

        // R2 reset request self-clears
        wr(12'h000, 32'hABCD_0003);
        rd(12'h000, a0, a1); check("R2 info bit0", a0, 32'hABCD_0002);

        // R3 plain storage
        wr(12'h008, 32'h1111_2222); wr(12'h0EC, 32'h0000_0001); wr(12'h0F0, 32'hF0F0_0F0F);
        rd(12'h008, a0, a1); check("R3 bus", a0, 32'h1111_2222);
        rd(12'h0EC, a0, a1); check("R3 wp", a0, 32'h0000_0001);
        rd(12'h0F0, a0, a1); check("R3 cdet", a0, 32'hF0F0_0F0F);

        // R4 capability halves
        wr(12'h010, 32'hDEAD_BEEF);
        rd(12'h014, a0, a1); check("R4 cap0 hi kept", a0, CAP_R[63:32]);
        rd(12'h010, a0, a1); check("R4 cap0 lo", a0, 32'hDEAD_BEEF);
        wr(12'h024, 32'h1234_5678);
        rd(12'h020, a0, a1); check("R4 cap1 lo kept", a0, CAP_R[31:0]);
        rd(12'h024, a0, a1); check("R4 cap1 hi", a0, 32'h1234_5678);
        check("R8 cap1 write dropped", a1, 32'h0);

        // R5 maximum current
        wr(12'h018, 32'h0000_00A5); wr(12'h028, 32'h0000_005A);
        rd(12'h018, a0, a1); check("R5 maxcur0", a0, 32'h0000_00A5);
        rd(12'h028, a0, a1); check("R5 maxcur1", a0, 32'h0000_005A);
        check("R8 maxcur1 one slot", a1, 32'h0);

        // R9 unmapped and misaligned
        wr(12'h00C, 32'hFFFF_FFFF); wr(12'h012, 32'h5555_5555);
        rd(12'h00C, a0, a1); check("R9 unmapped read", a0, 32'h0);
        rd(12'h011, a0, a1); check("R9 misaligned read", a0, 32'h0);
        rd(12'h010, a0, a1); check("R9 misaligned write dropped", a0, 32'hDEAD_BEEF);

        // R11 slot bank select
        req_addr = 12'h1A0; #1;
        check("R11 sel slot0", {28'b0, sel1, sel0}, 32'h5);
        req_addr = 12'h2F0; #1;
        check("R11 sel slot1", {30'b0, sel0}, 32'h2);
        check("R8 sel slot1 one slot", {30'b0, sel1}, 32'h0);
        req_addr = 12'h300; #1;
        check("R11 sel none", {28'b0, sel1, sel0}, 32'h0);

        // R6 R7 interrupt collection
        @(negedge clk); slot_irq_in = 2'b01;
        @(negedge clk);
        check("R7 irq from slot0", {30'b0, irq1, irq0}, 32'h3);
        rd(12'h0FC, a0, a1); check("R6 status slot0", a0, 32'h1);
        slot_irq_in = 2'b11;
        rd(12'h0FC, a0, a1); check("R6 status both", a0, 32'h3);
        check("R8 status one slot", a1, 32'h1);
        wr(12'h0FC, 32'h0);
        rd(12'h0FC, a0, a1); check("R6 write ignored", a0, 32'h3);
        slot_irq_in = 2'b10;
        @(negedge clk); @(negedge clk);
        check("R7 irq slot1 only", {30'b0, irq1, irq0}, 32'h1);
        slot_irq_in = 2'b00;
        @(negedge clk);
        check("R7 irq cleared", {31'b0, irq0}, 32'h0);
        // same-edge status read and interrupt rise
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 12'h0FC; slot_irq_in = 2'b10;
        @(negedge clk);
        req_valid = 1'b0;
        check("R6 read sees old status", rd0, 32'h0);
        check("R7 irq same edge", {30'b0, irq1, irq0}, 32'h1);
        @(negedge clk);
        slot_irq_in = 2'b00;

        // random traffic against the model, R3 R4 R5 R9
        for (int i = 0; i < 300; i++) begin
            logic [11:0] a;
            a = offs[$urandom_range(0, 12)];
            if ($urandom_range(0, 1) == 1) wr(a, $urandom);
            else begin
                rd(a, a0, a1);
                check("R3 R4 R5 R9 random", a0, exp_rd(a));
            end
        end

        check("R10 handshake timing", hs_bad, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule